// File: doc/BRIEF.md
# Weighted Time-Slice Cyclic Arbiter

This block shares one resource among a fixed number of requesters. Requesters are visited in a fixed cyclic order. Each one keeps the grant for a run of clock cycles equal to its own compile-time slice length. Bandwidth is therefore split in set proportions rather than equally. For example, slice lengths of 3 and 7 give the two requesters 30% and 70% of the grant cycles.

A single register holds the index of the current owner. A down-counter tracks how much of its slice is left. A combinational search picks the successor. A requester whose line is low is passed over at once and spends none of the shared time. If the owner lowers its line early, the grant moves in that same cycle. When nothing is requested, the grant is zero and the owner index is kept, so the rotation resumes where it stopped.

Top module: `wrr_slice_arbiter`

## Requirements
- R1: After synchronous reset the grant is all zero while no line requests. Requester 0 is the first candidate, so with every line high the first grant goes to requester 0 (grant bit i belongs to requester i).
- R2: The grant has at most one bit set, and a grant bit is high only while the same requester's request bit is high in that cycle.
- R3: A requester that keeps its line high holds the grant for exactly its slice length in consecutive cycles before the grant moves to another requester that is waiting. Slice length i sits in bits [i*CNT_W +: CNT_W] of SLICE_LEN; the defaults are 2, 3 and 5 for requesters 0, 1 and 2.
- R4: When a slice ends, the grant goes to the first requesting index found by searching upward from the current owner plus one, wrapping from N_REQ-1 to 0.
- R5: A requester with its line low is skipped without an idle cycle: whenever any request is high, some grant is high.
- R6: If the owner lowers its request before its slice ends, the next requester in cyclic order is granted in that same cycle and receives a full slice.
- R7: With no request high the grant is zero, and the next grant follows cyclic order from the last owner.
- R8: A lone requester keeps the grant in every cycle, with no gap when its slice reloads.
- R9: With every line held high, each window of sum-of-slices cycles that starts at a rotation boundary gives requester i exactly its slice length in grant cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N_REQ | Request line per requester |
| gnt | output | N_REQ | Grant, one-hot or zero |

## Verification
A corrupted owner index sends the grant to the wrong requester. It shows up at the first slice boundary, or in the same cycle if the corrupted index points at a requester that is not requesting. A slice counter that is off by one changes the run length of the first slice after reset. It is visible within the first rotation of sum-of-slices cycles when every line is high. A wrong search start breaks the R4 order at the next switch. A missing skip leaves the grant at zero while requests are pending, which is caught in that very cycle.

// File: rtl/wrr_pkg.sv
`timescale 1ns/1ps
package wrr_pkg;
    // width of an index into n entries, never below one bit
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/wrr_next_pick.sv
`timescale 1ns/1ps
// Cyclic search for the first request strictly after start, wrapping to start last.
module wrr_next_pick #(
    parameter int unsigned N_REQ = 3,
    parameter int unsigned IW    = 2
) (
    input  logic [N_REQ-1:0] req,
    input  logic [IW-1:0]    start,
    output logic             found,
    output logic [IW-1:0]    pick
);
    always_comb begin
        found = 1'b0;
        pick  = start;
        // walk from the farthest candidate back so the nearest one wins
        for (int k = N_REQ; k >= 1; k--) begin
            int idx;
            idx = (int'(start) + k) % N_REQ;
            if (req[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/wrr_weight_sel.sv
`timescale 1ns/1ps
// Selects the slice length of one requester from the packed parameter.
module wrr_weight_sel #(
    parameter int unsigned N_REQ = 3,
    parameter int unsigned CNT_W = 4,
    parameter int unsigned IW    = 2,
    parameter logic [N_REQ*CNT_W-1:0] SLICE_LEN = '1
) (
    input  logic [IW-1:0]    idx,
    output logic [CNT_W-1:0] len
);
    always_comb begin
        len = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (idx == IW'(i)) len = SLICE_LEN[i*CNT_W +: CNT_W];
        end
    end
endmodule

// File: rtl/wrr_slice_arbiter.sv
`timescale 1ns/1ps
module wrr_slice_arbiter #(
    parameter int unsigned N_REQ = 3,
    parameter int unsigned CNT_W = 4,
    parameter logic [N_REQ*CNT_W-1:0] SLICE_LEN = {4'd5, 4'd3, 4'd2}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] gnt
);
    localparam int unsigned IW = wrr_pkg::idx_bits(N_REQ);

    typedef struct packed {
        logic             active;  // an owner holds a live slice
        logic [IW-1:0]    ptr;     // current or last owner
        logic [CNT_W-1:0] left;    // cycles still owed after this one
    } arb_state_t;

    arb_state_t state_q, state_d;

    logic             cand_found;
    logic [IW-1:0]    cand_idx;
    logic [CNT_W-1:0] cand_len;

    wrr_next_pick #(.N_REQ(N_REQ), .IW(IW)) u_pick (
        .req   (req),
        .start (state_q.ptr),
        .found (cand_found),
        .pick  (cand_idx)
    );

    wrr_weight_sel #(.N_REQ(N_REQ), .CNT_W(CNT_W), .IW(IW), .SLICE_LEN(SLICE_LEN)) u_len (
        .idx (cand_idx),
        .len (cand_len)
    );

    always_comb begin
        state_d = state_q;
        gnt     = '0;
        if (state_q.active && req[state_q.ptr] && (state_q.left != '0)) begin
            gnt[state_q.ptr] = 1'b1;
            state_d.left     = state_q.left - 1'b1;
        end else if (cand_found) begin
            gnt[cand_idx]  = 1'b1;
            state_d.active = 1'b1;
            state_d.ptr    = cand_idx;
            state_d.left   = cand_len - 1'b1;
        end else begin
            state_d.active = 1'b0;
            state_d.left   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.active <= 1'b0;
            state_q.ptr    <= IW'(N_REQ - 1);
            state_q.left   <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/wrr_slice_arbiter_chk.sv
`timescale 1ns/1ps
module wrr_slice_arbiter_chk #(
    parameter int unsigned N_REQ = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [N_REQ-1:0] req,
    input logic [N_REQ-1:0] gnt
);
    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
    // R2
    grant_has_req_chk: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0);
    // R5
    no_idle_gap_chk: assert property (@(posedge clk) disable iff (rst) (req != '0) |-> (gnt != '0));
    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst) (req == '0) |-> (gnt == '0));
    // R8
    lone_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(gnt) != '0) && (req == $past(gnt))) |-> (gnt == req));
endmodule

bind wrr_slice_arbiter wrr_slice_arbiter_chk #(.N_REQ(N_REQ)) u_chk (
    .clk (clk),
    .rst (rst),
    .req (req),
    .gnt (gnt)
);

// File: tb/test_wrr_slice_arbiter.sv
`timescale 1ns/1ps
module test_wrr_slice_arbiter;
    localparam int N = 3;
    localparam int WT [N] = '{2, 3, 5};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] gnt;

    int checks = 0;
    int failures = 0;
    int m_act, m_ptr, m_left;
    logic [N-1:0] last_exp;

    always #2.5 clk = ~clk;

    wrr_slice_arbiter #(.N_REQ(N), .CNT_W(4), .SLICE_LEN({4'd5, 4'd3, 4'd2})) i_wrr_slice_arbiter (
        .clk (clk), .rst (rst), .req (req), .gnt (gnt)
    );

    task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // spec model: returns expected grant for request r and advances one cycle
    function automatic logic [N-1:0] model(input logic [N-1:0] r);
        logic [N-1:0] e = '0;
        if (m_act != 0 && r[m_ptr] && m_left != 0) begin
            e[m_ptr] = 1'b1;
            m_left--;
            return e;
        end
        for (int k = 1; k <= N; k++) begin
            int idx = (m_ptr + k) % N;
            if (r[idx]) begin
                e[idx] = 1'b1;
                m_ptr = idx;
                m_left = WT[idx] - 1;
                m_act = 1;
                return e;
            end
        end
        m_act = 0;
        m_left = 0;
        return e;
    endfunction

    task automatic step(input logic [N-1:0] r, input string tag);
        @(negedge clk);
        req = r;
        #1;
        last_exp = model(r);
        check(gnt === last_exp, tag, gnt, last_exp);
        check($onehot0(gnt) && ((gnt & ~req) == '0), "R2", gnt, last_exp);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seq [11] = '{1, 1, 2, 2, 2, 4, 4, 4, 4, 4, 1};
        int cnt [N];
        logic [N-1:0] r;
        void'($urandom(32'd2718));
        m_act = 0; m_ptr = N - 1; m_left = 0;
        repeat (3) @(posedge clk);
        #1;
        check(gnt === '0, "R1 reset grant", gnt, '0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R3 R4 R9: full rotation with every line high
        foreach (cnt[i]) cnt[i] = 0;
        for (int c = 0; c < 11; c++) begin
            step(3'b111, "R3 rotation");
            check(gnt === N'(seq[c]), "R4 R1 order", gnt, N'(seq[c]));
            if (c < 10) for (int i = 0; i < N; i++) if (gnt[i]) cnt[i]++;
        end
        for (int i = 0; i < N; i++)
            check(cnt[i] == WT[i], "R9 share", N'(cnt[i]), N'(WT[i]));

        // R5: requester 1 skipped
        for (int c = 0; c < 15; c++) step(3'b101, "R5 skip");

        // R6: owner drops early
        while (last_exp != 3'b100) step(3'b111, "R6 reach owner2");
        step(3'b011, "R6 drop switch");
        check(gnt === 3'b001, "R6 immediate", gnt, 3'b001);
        step(3'b011, "R6 full slice");
        check(gnt === 3'b001, "R6 full slice", gnt, 3'b001);

        // R7: idle and resume
        for (int c = 0; c < 4; c++) step(3'b000, "R7 idle");
        step(3'b111, "R7 resume");
        check(gnt === 3'b010, "R7 resume order", gnt, 3'b010);

        // R8: lone requester
        for (int c = 0; c < 12; c++) begin
            step(3'b100, "R8 lone");
            check(gnt === 3'b100, "R8 no gap", gnt, 3'b100);
        end

        // random mix, lines toggle with probability 1/6
        r = 3'b111;
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < N; i++) if ($urandom_range(5) == 0) r[i] = ~r[i];
            step(r, "R4 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule